// File: doc/BRIEF.md
# Pseudo-Static RAM Refresh Sequencer

This block is the refresh controller of a pseudo-static RAM, written as synchronous logic on a free-running clock. It watches the chip-select line, the shared output-enable/refresh strobe and an access-in-progress flag from the read/write path. When the device is deselected and idle, it measures how long the strobe is held low. A short low pulse requests one automatic row refresh. A long low pulse puts the device into self refresh, where an internal timer issues row refreshes on its own until the strobe returns high. Every refreshed row comes from an internal wrapping row counter, so the host never supplies a refresh address.

The thresholds are parameters counted in clock cycles: the minimum valid pulse width, the self-refresh entry threshold, the spacing of rows in self refresh, and the recovery gap after self refresh. There is no data stream through the block. All pins are plain level control and status signals with no handshake. `row_stb` is a one-cycle strobe that the array control samples together with `row_addr`.

Top module: `refresh_sequencer`

## Requirements
- R1: After reset, `row_addr` is 0, and `row_stb`, `refresh_busy`, `self_active` and `pulse_viol` are all 0.
- R2: While `chip_sel_n` is 0 or `access_busy` is 1, strobe activity starts no refresh. `row_stb`, `pulse_viol` and `refresh_busy` stay 0.
- R3: Refresh is armed only after the strobe is sampled high while the device is in standby (`chip_sel_n`=1, `access_busy`=0). A strobe that is already low when standby begins starts nothing until it has gone high and then low again.
- R4: An armed low pulse of L sampled cycles, with MIN_PULSE_CYC <= L < SELF_THRESH_CYC, gives exactly one one-cycle `row_stb`. The strobe appears in the cycle after the strobe is first sampled high again. `refresh_busy` is 1 for exactly L cycles.
- R5: An armed low pulse of L < MIN_PULSE_CYC cycles gives a one-cycle `pulse_viol`. It gives no `row_stb`, and the row counter does not change.
- R6: When the strobe stays low for SELF_THRESH_CYC sampled cycles, `self_active` rises after the last of those samples and one `row_stb` is issued at once. Further strobes follow every ROW_PERIOD_CYC cycles while the strobe stays low. A low of L cycles gives (L-SELF_THRESH_CYC)/ROW_PERIOD_CYC+1 strobes and L-SELF_THRESH_CYC+1 cycles of `self_active`.
- R7: A strobe high sample ends self refresh with no further `row_stb`. `refresh_busy` then stays 1 for RESET_GAP_CYC more cycles, and low strobe samples in that gap are ignored. After the gap, a new high then a new low is needed to start a refresh.
- R8: While `row_stb` is 1, `row_addr` shows the row being refreshed. The counter increases by one after each strobe, wraps from 2047 to 0 (11 bits), and holds otherwise.
- R9: If `chip_sel_n` falls while a low pulse is being measured, the measurement is dropped. No `row_stb` or `pulse_viol` results, and the device must re-arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Chip enable, active low; 1 means standby |
| access_busy | input | 1 | A read/write cycle is still in progress |
| strobe_n | input | 1 | Shared output-enable / refresh strobe, active low |
| row_stb | output | 1 | One-cycle row refresh strobe |
| row_addr | output | ROW_BITS | Row to refresh, from the internal counter |
| refresh_busy | output | 1 | Measuring, self-refreshing or recovering |
| self_active | output | 1 | Self refresh in progress |
| pulse_viol | output | 1 | One-cycle flag for a too-short refresh pulse |

## Verification
The assertions check the following on every cycle:
- `row_stb` lasts one cycle.
- The row counter steps by exactly one after each strobe and holds at all other times.
- A violation never coincides with a strobe.
- Self refresh implies busy.
- Leaving self refresh produces no strobe and keeps the device busy.
- Two idle cycles in a row produce no strobe or violation.

Only the bench scenarios can show the pulse-width classification at its exact boundaries, the number of strobes and busy cycles per pulse, the arming rule after an access, the abort on chip select, the ignored lows during recovery and the counter wrap.

// File: rtl/rfr_pkg.sv
package rfr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_MEASURE = 2'd1,
    ST_SELF    = 2'd2,
    ST_RECOVER = 2'd3
  } rfr_state_e;
endpackage

// File: rtl/rfr_arm_gate.sv
// Arms refresh once the strobe has been seen high in standby, and reports
// a start when an armed strobe is then sampled low.
module rfr_arm_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic standby,
  input  logic idle,
  input  logic strobe_n,
  output logic start
);
  logic armed;

  assign start = idle && standby && armed && !strobe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 armed <= 1'b0;
    else if (!standby)          armed <= 1'b0;
    else if (start)             armed <= 1'b0;
    else if (idle && strobe_n)  armed <= 1'b1;
  end
endmodule

// File: rtl/rfr_pace_timer.sv
// Spaces row refreshes while self refresh runs.
module rfr_pace_timer #(
  parameter int PERIOD = 1500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] pcnt;

  assign tick = run && (pcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pcnt <= '0;
    else if (!run)  pcnt <= '0;
    else if (tick)  pcnt <= '0;
    else            pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/rfr_row_counter.sv
// Holds the refresh row; steps one row after each strobe and wraps.
module rfr_row_counter #(
  parameter int ROW_BITS = 11
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                advance,
  output logic [ROW_BITS-1:0] row
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        row <= '0;
    else if (advance)  row <= row + 1'b1;
  end
endmodule

// File: rtl/rfr_width_fsm.sv
// Measures the low pulse width, picks automatic or self refresh, and
// counts the recovery gap after self refresh.
module rfr_width_fsm
  import rfr_pkg::*;
#(
  parameter int MIN_PULSE_CYC   = 8,
  parameter int SELF_THRESH_CYC = 800,
  parameter int RESET_GAP_CYC   = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       standby,
  input  logic       strobe_n,
  input  logic       pace_tick,
  output rfr_state_e state,
  output logic       fire_q,
  output logic       viol_q
);
  localparam int CMAX = (SELF_THRESH_CYC > RESET_GAP_CYC) ? SELF_THRESH_CYC : RESET_GAP_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] MIN_W   = CW'(MIN_PULSE_CYC);
  localparam logic [CW-1:0] SELF_W  = CW'(SELF_THRESH_CYC - 1);
  localparam logic [CW-1:0] GAP_END = CW'(RESET_GAP_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      fire_q <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      viol_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_MEASURE;
            cnt   <= CW'(1);
          end
        end
        ST_MEASURE: begin
          if (!standby) begin
            state <= ST_IDLE;
          end else if (strobe_n) begin
            state <= ST_IDLE;
            if (cnt >= MIN_W) fire_q <= 1'b1;
            else              viol_q <= 1'b1;
          end else if (cnt == SELF_W) begin
            state  <= ST_SELF;
            fire_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SELF: begin
          if (strobe_n) begin
            state <= ST_RECOVER;
            cnt   <= '0;
          end else if (pace_tick) begin
            fire_q <= 1'b1;
          end
        end
        default: begin
          if (cnt == GAP_END) state <= ST_IDLE;
          else                cnt   <= cnt + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
  import rfr_pkg::*;
#(
  parameter int ROW_BITS        = 11,
  parameter int MIN_PULSE_CYC   = 8,
  parameter int SELF_THRESH_CYC = 800,
  parameter int ROW_PERIOD_CYC  = 1500,
  parameter int RESET_GAP_CYC   = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chip_sel_n,
  input  logic                access_busy,
  input  logic                strobe_n,
  output logic                row_stb,
  output logic [ROW_BITS-1:0] row_addr,
  output logic                refresh_busy,
  output logic                self_active,
  output logic                pulse_viol
);
  rfr_state_e state;
  logic standby, start, tick, fire, viol;

  assign standby = chip_sel_n && !access_busy;

  rfr_arm_gate u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .standby  (standby),
    .idle     (state == ST_IDLE),
    .strobe_n (strobe_n),
    .start    (start)
  );

  rfr_width_fsm #(
    .MIN_PULSE_CYC   (MIN_PULSE_CYC),
    .SELF_THRESH_CYC (SELF_THRESH_CYC),
    .RESET_GAP_CYC   (RESET_GAP_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .standby   (standby),
    .strobe_n  (strobe_n),
    .pace_tick (tick),
    .state     (state),
    .fire_q    (fire),
    .viol_q    (viol)
  );

  rfr_pace_timer #(
    .PERIOD (ROW_PERIOD_CYC)
  ) u_pace (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state == ST_SELF),
    .tick  (tick)
  );

  rfr_row_counter #(
    .ROW_BITS (ROW_BITS)
  ) u_rows (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (fire),
    .row     (row_addr)
  );

  assign row_stb      = fire;
  assign pulse_viol   = viol;
  assign self_active  = (state == ST_SELF);
  assign refresh_busy = (state != ST_IDLE);
endmodule

// File: rtl/refresh_sequencer_checks.sv
module refresh_sequencer_checks #(
  parameter int ROW_BITS = 11
) (
  input logic                clk,
  input logic                rst_n,
  input logic                row_stb,
  input logic [ROW_BITS-1:0] row_addr,
  input logic                refresh_busy,
  input logic                self_active,
  input logic                pulse_viol
);
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |=> !row_stb); // R4
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb |=> row_addr == ROW_BITS'($past(row_addr) + 1'b1)); // R8
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !row_stb |=> row_addr == $past(row_addr)); // R8
  AST_VIOL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_viol |-> !row_stb); // R5
  AST_SELF_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    self_active |-> refresh_busy); // R6
  AST_EXIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(self_active) |-> !row_stb); // R7
  AST_EXIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(self_active) |-> refresh_busy); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!refresh_busy && !$past(refresh_busy)) |-> (!row_stb && !pulse_viol)); // R2
endmodule

bind refresh_sequencer refresh_sequencer_checks #(.ROW_BITS(ROW_BITS)) u_checks (
  .clk          (clk),
  .rst_n        (rst_n),
  .row_stb      (row_stb),
  .row_addr     (row_addr),
  .refresh_busy (refresh_busy),
  .self_active  (self_active),
  .pulse_viol   (pulse_viol)
);

// File: tb/test_refresh_sequencer.sv
module test_refresh_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int RB  = 11;
  localparam int MIN = 4;
  localparam int THR = 40;
  localparam int PER = 4;
  localparam int GAP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_sel_n = 1'b1;
  logic access_busy = 1'b0;
  logic strobe_n = 1'b1;
  logic row_stb, refresh_busy, self_active, pulse_viol;
  logic [RB-1:0] row_addr;

  int checks = 0;
  int errors = 0;
  int exp_row = 0;
  bit done = 1'b0;
  bit seen_wrap = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refresh_sequencer #(
    .ROW_BITS(RB), .MIN_PULSE_CYC(MIN), .SELF_THRESH_CYC(THR),
    .ROW_PERIOD_CYC(PER), .RESET_GAP_CYC(GAP)
  ) i_refresh_sequencer (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .access_busy(access_busy),
    .strobe_n(strobe_n), .row_stb(row_stb), .row_addr(row_addr),
    .refresh_busy(refresh_busy), .self_active(self_active), .pulse_viol(pulse_viol)
  );

  function automatic int exp_stb(int l);
    if (l < MIN) return 0;
    if (l < THR) return 1;
    return (l - THR) / PER + 1;
  endfunction
  function automatic int exp_viol(int l);
    return (l < MIN) ? 1 : 0;
  endfunction
  function automatic int exp_self(int l);
    return (l >= THR) ? (l - THR + 1) : 0;
  endfunction
  function automatic int exp_busy(int l);
    return (l >= THR) ? (l + GAP) : l;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  int n_stb, n_viol, n_self, n_busy;

  task automatic observe();
    if (row_stb) begin
      n_stb++;
      check(row_addr == RB'(exp_row), "R8", "strobed row", row_addr, exp_row);
      if (exp_row == (1 << RB) - 1) seen_wrap = 1'b1;
      exp_row = (exp_row + 1) % (1 << RB);
    end
    if (pulse_viol)   n_viol++;
    if (self_active)  n_self++;
    if (refresh_busy) n_busy++;
  endtask

  task automatic clear_counts();
    n_stb = 0; n_viol = 0; n_self = 0; n_busy = 0;
  endtask

  task automatic idle_high(int n);
    strobe_n = 1'b1;
    repeat (n) begin @(negedge clk); observe(); end
  endtask

  // Armed low pulse of l samples, then a quiet window.
  task automatic do_pulse(int l, string req);
    clear_counts();
    strobe_n = 1'b0;
    for (int i = 0; i < l; i++) begin @(negedge clk); observe(); end
    strobe_n = 1'b1;
    for (int j = 0; j < GAP + 4; j++) begin @(negedge clk); observe(); end
    check(n_stb == exp_stb(l), req, $sformatf("strobes L=%0d", l), n_stb, exp_stb(l));
    check(n_viol == exp_viol(l), req, $sformatf("violations L=%0d", l), n_viol, exp_viol(l));
    check(n_self == exp_self(l), req, $sformatf("self cycles L=%0d", l), n_self, exp_self(l));
    check(n_busy == exp_busy(l), req, $sformatf("busy cycles L=%0d", l), n_busy, exp_busy(l));
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1: reset state
    check(row_addr == 0 && !row_stb && !refresh_busy && !self_active && !pulse_viol,
          "R1", "reset outputs", {row_stb, refresh_busy, self_active, pulse_viol}, 0);
    rst_n = 1'b1;
    idle_high(3);

    // R4 boundaries
    do_pulse(MIN, "R4");
    do_pulse(THR - 1, "R4");
    // R5 boundaries: counter must not move (checked by strobed row later)
    do_pulse(1, "R5");
    do_pulse(MIN - 1, "R5");
    do_pulse(MIN + 1, "R5");
    // R6 boundaries
    do_pulse(THR, "R6");
    do_pulse(THR + PER, "R6");
    do_pulse(THR + 3 * PER + 2, "R6");

    // R2: deselected and during access, lows start nothing
    clear_counts();
    chip_sel_n = 1'b0;
    strobe_n = 1'b0;
    repeat (12) begin @(negedge clk); observe(); end
    strobe_n = 1'b1; chip_sel_n = 1'b1; access_busy = 1'b1;
    @(negedge clk); observe();
    strobe_n = 1'b0;
    repeat (12) begin @(negedge clk); observe(); end
    check(n_stb == 0 && n_viol == 0, "R2", "events while not in standby", n_stb + n_viol, 0);
    check(n_busy == 0, "R2", "busy while not in standby", n_busy, 0);

    // R3: low held from access into standby starts nothing
    clear_counts();
    access_busy = 1'b0;
    repeat (12) begin @(negedge clk); observe(); end
    check(n_stb == 0 && n_busy == 0, "R3", "unarmed low held into standby", n_stb + n_busy, 0);
    idle_high(2);
    do_pulse(MIN + 2, "R3");

    // R9: chip select falls during measurement
    clear_counts();
    strobe_n = 1'b0;
    repeat (3) begin @(negedge clk); observe(); end
    chip_sel_n = 1'b0;
    @(negedge clk); observe();
    chip_sel_n = 1'b1;
    repeat (3) begin @(negedge clk); observe(); end
    strobe_n = 1'b1;
    repeat (GAP + 4) begin @(negedge clk); observe(); end
    check(n_stb == 0 && n_viol == 0, "R9", "aborted pulse events", n_stb + n_viol, 0);
    do_pulse(MIN + 3, "R9");

    // R7: lows during the recovery gap are ignored
    clear_counts();
    strobe_n = 1'b0;
    repeat (THR + 2) begin @(negedge clk); observe(); end
    strobe_n = 1'b1;
    repeat (2) begin @(negedge clk); observe(); end
    strobe_n = 1'b0;
    repeat (2) begin @(negedge clk); observe(); end
    strobe_n = 1'b1;
    repeat (GAP + 8) begin @(negedge clk); observe(); end
    check(n_stb == 1, "R7", "strobes with lows in gap", n_stb, 1);
    check(n_viol == 0, "R7", "violations with lows in gap", n_viol, 0);
    check(n_busy == THR + 2 + GAP, "R7", "busy with lows in gap", n_busy, THR + 2 + GAP);

    // Random widths
    for (int k = 0; k < 40; k++) begin
      int l;
      l = $urandom_range(1, THR + 3 * PER);
      do_pulse(l, (l < MIN) ? "R5" : (l < THR) ? "R4" : "R6");
    end

    // R8 wrap through a long self refresh
    do_pulse(THR + PER * 2100, "R8");
    check(seen_wrap, "R8", "row counter wrapped", seen_wrap, 1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule